// File: doc/BRIEF.md
# Decode-Stage Branch-If-Equal Resolver

This block settles a conditional branch-if-equal while the branch sits in the decode stage of a five-stage pipeline. The front end always assumes the branch falls through and keeps fetching from the next sequential address. The resolver computes the branch destination with an adder of its own. That adder sums the incremented program counter held in the fetch/decode register and the sign-extended offset, shifted left by two. The resolver compares the two register operands with a bitwise XOR whose bits are then ORed together. It does not use the ALU for this.

When the branch turns out to be taken, only the single instruction fetched behind it is on the wrong path. In that cycle the resolver raises two signals together. The redirect select moves the PC onto the target. The flush strobe zeroes the instruction field of the fetch/decode register, so the wrong-path instruction becomes a nop. A taken branch therefore costs one cycle.

A stall from the hazard unit holds the branch back until the stall is released. Two saturating counters record how many redirects and how many flushes have happened. A bench compares these against the number of taken branches it expects in an instruction stream.

Top module: `id_branch_resolve`

## Requirements
- R1: While `br_valid` is 0, `redirect` and `if_flush` stay 0 whatever the operands are, and neither counter moves.
- R2: `br_target` always equals `pc_plus4 + (imm_ext << 2)` modulo 2^AW. This holds whether or not a branch is present. A negative offset moves the target below `pc_plus4`.
- R3: A branch counts as equal only when every bit of `opnd_a` matches `opnd_b`. A difference in any single bit position gives not taken, with `redirect` and `if_flush` left at 0.
- R4: With `br_valid` at 1, `stall` at 0 and equal operands, `redirect` and `if_flush` both go to 1 in the same cycle the inputs are presented. There is no register on that path.
- R5: While `stall` is 1, `redirect` and `if_flush` stay 0 even for an equal branch. Once `stall` falls with the same inputs, the redirect happens in that cycle.
- R6: On each rising clock edge where `redirect` is 1, `taken_cnt` rises by one. On each rising edge where `if_flush` is 1, `flush_cnt` rises by one. Both counters hold at all ones and do not wrap.
- R7: An active-low `rst_n` clears both counters to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the counters |
| stall | input | 1 | Hazard-unit stall; holds the branch decision back |
| br_valid | input | 1 | Decoded instruction is a branch-if-equal |
| pc_plus4 | input | AW | Incremented PC from the fetch/decode register |
| imm_ext | input | AW | Sign-extended branch offset in words |
| opnd_a | input | DW | First register operand |
| opnd_b | input | DW | Second register operand |
| redirect | output | 1 | 1 selects `br_target` as the next PC |
| br_target | output | AW | Branch destination address |
| if_flush | output | 1 | Zeroes the fetch/decode instruction field |
| taken_cnt | output | CNT_W | Saturating count of redirect cycles |
| flush_cnt | output | CNT_W | Saturating count of flush cycles |

## Verification
The properties take for granted that the operand values arriving in decode are already correct, because the block does no forwarding. They also assume `stall` and `br_valid` are defined levels that stay steady across each clock edge. The stimulus respects both assumptions. It changes every input only on the falling edge and never leaves an input unknown after reset. It feeds operands that the bench itself chooses as final values. It also holds a stalled branch unchanged until the stall is lifted, just as the hazard unit would.

// File: rtl/brt_pkg.sv
package brt_pkg;

   typedef enum logic {
      PC_SEQ    = 1'b0,
      PC_BRANCH = 1'b1
   } pc_src_e;

   function automatic int unsigned pow2_ceil(input int unsigned n);
      int unsigned p;
      p = 1;
      while (p < n) p = p * 2;
      return p;
   endfunction

endpackage

// File: rtl/brt_eq_detect.sv
module brt_eq_detect #(
   parameter int unsigned DW      = 32,
   parameter int unsigned EQ_TREE = 1
) (
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   output logic          same
);
   import brt_pkg::*;

   localparam int unsigned PW = pow2_ceil(DW);

   logic [DW-1:0] diff;
   assign diff = a ^ b;

   generate
      if (EQ_TREE != 0) begin : g_tree
         function automatic logic or_tree(input logic [PW-1:0] v);
            logic [PW-1:0] t;
            t = v;
            for (int w = PW / 2; w >= 1; w = w / 2) begin
               for (int k = 0; k < w; k++) begin
                  t[k] = t[2*k] | t[2*k+1];
               end
            end
            return t[0];
         endfunction

         logic [PW-1:0] diff_pad;
         always_comb begin
            diff_pad          = '0;
            diff_pad[DW-1:0]  = diff;
         end
         assign same = ~or_tree(diff_pad);
      end else begin : g_flat
         assign same = ~(|diff);
      end
   endgenerate

endmodule

// File: rtl/brt_target_add.sv
module brt_target_add #(
   parameter int unsigned AW    = 32,
   parameter int unsigned SHIFT = 2
) (
   input  logic [AW-1:0] pc_next,
   input  logic [AW-1:0] offset,
   output logic [AW-1:0] target
);
   logic [AW-1:0] offset_bytes;

   assign offset_bytes = offset << SHIFT;
   assign target       = pc_next + offset_bytes;

endmodule

// File: rtl/brt_redirect_ctl.sv
module brt_redirect_ctl (
   input  logic              is_branch,
   input  logic              operands_same,
   input  logic              hold,
   output brt_pkg::pc_src_e  pc_src,
   output logic              flush
);
   import brt_pkg::*;

   logic resolve_now;

   always_comb begin
      resolve_now = is_branch & ~hold;
      pc_src      = PC_SEQ;
      flush       = 1'b0;
      if (resolve_now && operands_same) begin
         pc_src = PC_BRANCH;
         flush  = 1'b1;
      end
   end

endmodule

// File: rtl/brt_event_count.sv
module brt_event_count #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         hit,
   output logic [W-1:0] count
);
   localparam logic [W-1:0] CMAX = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (hit && (count != CMAX)) begin
         count <= count + 1'b1;
      end
   end

endmodule

// File: rtl/id_branch_resolve.sv
module id_branch_resolve #(
   parameter int unsigned AW      = 32,
   parameter int unsigned DW      = 32,
   parameter int unsigned SHIFT   = 2,
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned EQ_TREE = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stall,
   input  logic             br_valid,
   input  logic [AW-1:0]    pc_plus4,
   input  logic [AW-1:0]    imm_ext,
   input  logic [DW-1:0]    opnd_a,
   input  logic [DW-1:0]    opnd_b,
   output logic             redirect,
   output logic [AW-1:0]    br_target,
   output logic             if_flush,
   output logic [CNT_W-1:0] taken_cnt,
   output logic [CNT_W-1:0] flush_cnt
);
   import brt_pkg::*;

   generate
      if (AW < SHIFT + 1) begin : g_bad_aw
         $error("id_branch_resolve: AW must exceed SHIFT");
      end
      if (DW < 1) begin : g_bad_dw
         $error("id_branch_resolve: DW must be at least 1");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("id_branch_resolve: CNT_W must be at least 1");
      end
   endgenerate

   logic     ops_same;
   pc_src_e  pc_src;
   logic     flush_int;

   brt_eq_detect #(.DW(DW), .EQ_TREE(EQ_TREE)) u_eq (
      .a    (opnd_a),
      .b    (opnd_b),
      .same (ops_same)
   );

   brt_target_add #(.AW(AW), .SHIFT(SHIFT)) u_add (
      .pc_next (pc_plus4),
      .offset  (imm_ext),
      .target  (br_target)
   );

   brt_redirect_ctl u_ctl (
      .is_branch     (br_valid),
      .operands_same (ops_same),
      .hold          (stall),
      .pc_src        (pc_src),
      .flush         (flush_int)
   );

   assign redirect = (pc_src == PC_BRANCH);
   assign if_flush = flush_int;

   brt_event_count #(.W(CNT_W)) u_cnt_taken (
      .clk   (clk),
      .rst_n (rst_n),
      .hit   (redirect),
      .count (taken_cnt)
   );

   brt_event_count #(.W(CNT_W)) u_cnt_flush (
      .clk   (clk),
      .rst_n (rst_n),
      .hit   (if_flush),
      .count (flush_cnt)
   );

endmodule

// File: rtl/brt_checks.sv
module brt_checks #(
   parameter int unsigned AW    = 32,
   parameter int unsigned DW    = 32,
   parameter int unsigned SHIFT = 2,
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             stall,
   input logic             br_valid,
   input logic [AW-1:0]    pc_plus4,
   input logic [AW-1:0]    imm_ext,
   input logic [DW-1:0]    opnd_a,
   input logic [DW-1:0]    opnd_b,
   input logic             redirect,
   input logic [AW-1:0]    br_target,
   input logic             if_flush,
   input logic [CNT_W-1:0] taken_cnt,
   input logic [CNT_W-1:0] flush_cnt
);
   localparam logic [CNT_W-1:0] CMAX = '1;

   // R1: no branch, no redirect
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !br_valid |-> (!redirect && !if_flush));

   // R2: distance from pc_plus4 to target is the scaled offset
   p_target_span_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (br_target - pc_plus4) == (imm_ext << SHIFT));

   // R3: any mismatch keeps the PC sequential
   p_mismatch_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (opnd_a != opnd_b) |-> (!redirect && !if_flush));

   // R4: equal unstalled branch redirects and flushes together
   p_equal_taken_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid && !stall && (opnd_a == opnd_b)) |-> (redirect && if_flush));

   // R5: stall blocks the decision
   p_stall_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> (!redirect && !if_flush));

   // R6: counters step by one on a redirect and hold otherwise
   p_taken_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (redirect && (taken_cnt != CMAX)) |=> (taken_cnt == $past(taken_cnt) + 1'b1));

   p_taken_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !redirect |=> $stable(taken_cnt));

   p_flush_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (if_flush && (flush_cnt != CMAX)) |=> (flush_cnt == $past(flush_cnt) + 1'b1));

   p_flush_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_cnt == CMAX) |=> (flush_cnt == CMAX));

endmodule

bind id_branch_resolve brt_checks #(
   .AW(AW), .DW(DW), .SHIFT(SHIFT), .CNT_W(CNT_W)
) u_brt_checks (
   .clk       (clk),
   .rst_n     (rst_n),
   .stall     (stall),
   .br_valid  (br_valid),
   .pc_plus4  (pc_plus4),
   .imm_ext   (imm_ext),
   .opnd_a    (opnd_a),
   .opnd_b    (opnd_b),
   .redirect  (redirect),
   .br_target (br_target),
   .if_flush  (if_flush),
   .taken_cnt (taken_cnt),
   .flush_cnt (flush_cnt)
);

// File: tb/sim_id_branch_resolve.sv
`timescale 1ns/1ps
module sim_id_branch_resolve;
   localparam int unsigned AW    = 32;
   localparam int unsigned DW    = 32;
   localparam int unsigned CNT_W = 4;
   localparam logic [CNT_W-1:0] CMAX = '1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             stall = 1'b0;
   logic             br_valid = 1'b0;
   logic [AW-1:0]    pc_plus4 = '0;
   logic [AW-1:0]    imm_ext = '0;
   logic [DW-1:0]    opnd_a = '0;
   logic [DW-1:0]    opnd_b = '0;
   logic             redirect;
   logic [AW-1:0]    br_target;
   logic             if_flush;
   logic [CNT_W-1:0] taken_cnt;
   logic [CNT_W-1:0] flush_cnt;

   int n_chk  = 0;
   int n_fail = 0;
   logic [CNT_W-1:0] exp_cnt;
   logic exp_taken;

   always #5 clk = ~clk;

   id_branch_resolve #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) u0 (
      .clk(clk), .rst_n(rst_n), .stall(stall), .br_valid(br_valid),
      .pc_plus4(pc_plus4), .imm_ext(imm_ext), .opnd_a(opnd_a), .opnd_b(opnd_b),
      .redirect(redirect), .br_target(br_target), .if_flush(if_flush),
      .taken_cnt(taken_cnt), .flush_cnt(flush_cnt)
   );

   // expected taken decision from the requirements (R3, R4, R5)
   assign exp_taken = br_valid && !stall && (opnd_a == opnd_b);

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) exp_cnt <= '0;
      else if (exp_taken && exp_cnt != CMAX) exp_cnt <= exp_cnt + 1'b1;
   end

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic drive(input logic st, input logic bv, input logic [AW-1:0] pc,
                        input logic [AW-1:0] im, input logic [DW-1:0] a, input logic [DW-1:0] b);
      @(negedge clk);
      stall = st; br_valid = bv; pc_plus4 = pc; imm_ext = im; opnd_a = a; opnd_b = b;
      #1;
   endtask

   task automatic tick;
      @(posedge clk);
      #1;
   endtask

   task automatic t_reset;
      check("R7 taken_cnt after reset", taken_cnt, 0);
      check("R7 flush_cnt after reset", flush_cnt, 0);
      check("R1 redirect idle", redirect, 0);
   endtask

   task automatic t_no_branch;
      drive(0, 0, 32'h100, 32'h4, 32'h55, 32'h55);
      check("R1 redirect without branch", redirect, 0);
      check("R1 flush without branch", if_flush, 0);
      tick;
      check("R1 taken_cnt unchanged", taken_cnt, 0);
      check("R1 flush_cnt unchanged", flush_cnt, 0);
   endtask

   task automatic t_taken;
      drive(0, 1, 32'h200, 32'h8, 32'h1234, 32'h1234);
      check("R4 redirect same cycle", redirect, 1);
      check("R4 flush same cycle", if_flush, 1);
      check("R2 target forward", br_target, 32'h220);
      tick;
      check("R6 taken_cnt after one", taken_cnt, exp_cnt);
      check("R6 flush_cnt after one", flush_cnt, exp_cnt);
      drive(0, 1, 32'h300, 32'h0, 32'h0, 32'h0);
      check("R3 zero operands equal", redirect, 1);
      drive(0, 1, 32'h300, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      check("R3 all-ones operands equal", if_flush, 1);
      tick;
      check("R6 taken_cnt after three", taken_cnt, 3);
   endtask

   task automatic t_unequal;
      int pos [4] = '{0, 7, 16, 31};
      foreach (pos[i]) begin
         drive(0, 1, 32'h400, 32'h2, 32'hA5A5_5A5A, 32'hA5A5_5A5A ^ (32'h1 << pos[i]));
         check("R3 single-bit mismatch redirect", redirect, 0);
         check("R3 single-bit mismatch flush", if_flush, 0);
      end
      tick;
      check("R3 taken_cnt unchanged on mismatch", taken_cnt, 3);
   endtask

   task automatic t_target;
      drive(0, 0, 32'h0040_0010, 32'hFFFF_FFFF, 32'h1, 32'h2);
      check("R2 negative offset", br_target, 32'h0040_000C);
      drive(0, 0, 32'hFFFF_FFFC, 32'h1, 32'h1, 32'h2);
      check("R2 wraparound", br_target, 32'h0);
      drive(0, 1, 32'h1000, 32'hFFFF_FF00, 32'h3, 32'h4);
      check("R2 large negative offset", br_target, 32'h0C00);
   endtask

   task automatic t_stall;
      drive(1, 1, 32'h500, 32'h1, 32'h77, 32'h77);
      check("R5 stalled redirect", redirect, 0);
      check("R5 stalled flush", if_flush, 0);
      tick;
      check("R5 taken_cnt frozen in stall", taken_cnt, 3);
      drive(0, 1, 32'h500, 32'h1, 32'h77, 32'h77);
      check("R5 redirect after release", redirect, 1);
      check("R5 flush after release", if_flush, 1);
      tick;
      check("R5 taken_cnt after release", taken_cnt, 4);
   endtask

   task automatic t_saturate;
      drive(0, 1, 32'h600, 32'h1, 32'h9, 32'h9);
      for (int i = 0; i < 20; i++) tick;
      check("R6 taken_cnt saturates", taken_cnt, CMAX);
      check("R6 flush_cnt saturates", flush_cnt, CMAX);
      check("R6 model agrees", exp_cnt, CMAX);
      drive(0, 0, 32'h0, 32'h0, 32'h0, 32'h0);
      rst_n = 1'b0;
      #1;
      check("R7 taken_cnt cleared", taken_cnt, 0);
      check("R7 flush_cnt cleared", flush_cnt, 0);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      repeat (3) @(posedge clk);
      #1;
      t_reset;
      @(negedge clk);
      rst_n = 1'b1;
      t_no_branch;
      t_taken;
      t_unequal;
      t_target;
      t_stall;
      t_saturate;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule